// File: doc/BRIEF.md
# Inter-processor doorbell interrupt block

This block lets one processing agent ring doorbells on up to eleven peer agents and collect doorbells that they ring back. Software writes a one-hot or multi-hot word to the trigger register. Each valid bit in that word becomes a single-cycle pulse on the matching outbound trigger line. Peers raise inbound request lines, and the block latches each request into a sticky status bit. Every status bit is echoed to its sender on an outbound observation line, so the sender can see that its doorbell has not yet been serviced.

A mask, changed only through separate enable and disable registers, selects which latched status bits can raise the single interrupt output. A read-only observation register reports the levels of eleven inbound observation lines, so software can see the state of doorbells it has sent. The register interface is a simple one-cycle request with read data returned on the following cycle. Only full 32-bit accesses take effect.

Top module: `ipi_hub`

## Requirements
- R1: After reset the mask (offset 0x14) reads 0x0F0F0301, the status register reads zero, and trig_out, obs_out and irq are all low.
- R2: Channel port index i maps to register bit 0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27 for i = 0..10 respectively. Every other bit reads as zero and is ignored on write.
- R3: A full write to the trigger register (offset 0x00) drives each written valid bit onto its trig_out line for exactly the one cycle after the write. The trigger register always reads zero.
- R4: A high ch_req_in line sets its status bit (offset 0x10) from the next cycle. The bit stays set until software writes a 1 to that bit position. Writing 0 leaves it unchanged.
- R5: When a request and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R6: obs_out equals the current status bits at every cycle.
- R7: Writing 1s to the enable register (offset 0x18) clears the matching mask bits, and writing 1s to the disable register (offset 0x1C) sets them. Both registers read zero, and writes to the mask register have no effect.
- R8: irq is high exactly when some status bit is set while its mask bit is clear.
- R9: Reading the observation register (offset 0x04) returns the obs_in levels at their register bit positions. Writes to it have no effect.
- R10: rsp_rdata carries read data in the cycle after a read request and is zero in every other cycle. Reads of unmapped offsets return zero.
- R11: An access whose byte enables are not all ones has no effect, and a read made that way returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_be | input | DATA_W/8 | Byte enables; all ones for a legal access |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, one cycle after the request |
| ch_req_in | input | 11 | Inbound doorbell requests, one per channel |
| obs_in | input | 11 | Inbound observation levels, one per channel |
| trig_out | output | 11 | Outbound doorbell pulses, one per channel |
| obs_out | output | 11 | Echo of the latched status, one per channel |
| irq | output | 1 | Interrupt to the local agent |

## Verification
The hardest case to reach from the ports is a request landing in the very cycle that software clears the same status bit. That race decides whether a doorbell is lost. The stimulus holds a request line high across a clear write to force the collision, and the random phase also drives sparse requests during clear writes. Masked and unmasked channels are mixed, so irq is seen both suppressed and raised for the same latched status.

// File: rtl/ipi_hub_pkg.sv
package ipi_hub_pkg;

  localparam int NCH = 11;
  localparam int CW  = $clog2(NCH);

  typedef enum logic [2:0] {
    RID_TRIG,
    RID_OBS,
    RID_STAT,
    RID_MASK,
    RID_EN,
    RID_DIS,
    RID_NONE
  } reg_id_e;

  localparam logic [7:0] OFF_TRIG = 8'h00;
  localparam logic [7:0] OFF_OBS  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h10;
  localparam logic [7:0] OFF_MASK = 8'h14;
  localparam logic [7:0] OFF_EN   = 8'h18;
  localparam logic [7:0] OFF_DIS  = 8'h1C;

  // Register bit position of channel i: groups of 1, 2, 4 and 4 channels.
  function automatic int chan_bit(input int i);
    if (i == 0)      return 0;
    else if (i < 3)  return 7 + i;
    else if (i < 7)  return 13 + i;
    else             return 17 + i;
  endfunction

  function automatic int chan_of_bit(input int b);
    for (int i = 0; i < NCH; i++) begin
      if (chan_bit(i) == b) return i;
    end
    return -1;
  endfunction

  function automatic logic [31:0] valid_mask();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NCH; i++) m[chan_bit(i)] = 1'b1;
    return m;
  endfunction

  // Register word to channel vector; every word bit is visited.
  function automatic logic [NCH-1:0] gather(input logic [31:0] w);
    logic [NCH-1:0] v;
    int idx;
    v = '0;
    for (int b = 0; b < 32; b++) begin
      idx = chan_of_bit(b);
      if (idx >= 0) v[idx[CW-1:0]] = w[b];
    end
    return v;
  endfunction

  function automatic logic [31:0] scatter(input logic [NCH-1:0] v);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < NCH; i++) w[chan_bit(i)] = v[i];
    return w;
  endfunction

endpackage

// File: rtl/ipi_hub_decode.sv
module ipi_hub_decode
  import ipi_hub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              we_trig,
  output logic              we_stat,
  output logic              we_en,
  output logic              we_dis,
  output logic              re,
  output reg_id_e           rd_id,
  output logic [NCH-1:0]    wr_chan
);

  logic    acc;
  reg_id_e rid;

  always_comb begin
    acc = req_valid & (&req_be);
    if      (req_addr == ADDR_W'(OFF_TRIG)) rid = RID_TRIG;
    else if (req_addr == ADDR_W'(OFF_OBS))  rid = RID_OBS;
    else if (req_addr == ADDR_W'(OFF_STAT)) rid = RID_STAT;
    else if (req_addr == ADDR_W'(OFF_MASK)) rid = RID_MASK;
    else if (req_addr == ADDR_W'(OFF_EN))   rid = RID_EN;
    else if (req_addr == ADDR_W'(OFF_DIS))  rid = RID_DIS;
    else                                    rid = RID_NONE;
  end

  always_comb begin
    we_trig = acc & req_write & (rid == RID_TRIG);
    we_stat = acc & req_write & (rid == RID_STAT);
    we_en   = acc & req_write & (rid == RID_EN);
    we_dis  = acc & req_write & (rid == RID_DIS);
    re      = acc & ~req_write;
    rd_id   = rid;
    wr_chan = gather(32'(req_wdata));
  end

endmodule

// File: rtl/ipi_hub_core.sv
module ipi_hub_core
  import ipi_hub_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_trig,
  input  logic           we_stat,
  input  logic           we_en,
  input  logic           we_dis,
  input  logic [NCH-1:0] wr_chan,
  input  logic [NCH-1:0] ch_req_in,
  output logic [NCH-1:0] trig_q,
  output logic [NCH-1:0] stat_q,
  output logic [NCH-1:0] mask_q,
  output logic           irq
);

  logic [NCH-1:0] trig_d;
  logic [NCH-1:0] stat_d;
  logic [NCH-1:0] mask_d;
  logic           stat_en;
  logic           mask_en;

  always_comb begin
    trig_d  = we_trig ? wr_chan : '0;
    stat_en = we_stat | (|ch_req_in);
    mask_en = we_en | we_dis;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_comb begin
      // A request in the clearing cycle wins over the clear.
      stat_d[g] = ch_req_in[g] | (stat_q[g] & ~(we_stat & wr_chan[g]));
      if (we_en & wr_chan[g])       mask_d[g] = 1'b0;
      else if (we_dis & wr_chan[g]) mask_d[g] = 1'b1;
      else                          mask_d[g] = mask_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
    end else begin
      trig_q <= trig_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_comb begin
    irq = |(stat_q & ~mask_q);
  end

endmodule

// File: rtl/ipi_hub_rdmux.sv
module ipi_hub_rdmux
  import ipi_hub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  reg_id_e           rd_id,
  input  logic [NCH-1:0]    stat_q,
  input  logic [NCH-1:0]    mask_q,
  input  logic [NCH-1:0]    obs_in,
  output logic [DATA_W-1:0] rdata_q
);

  logic [31:0]       word;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    unique case (rd_id)
      RID_OBS:  word = scatter(obs_in);
      RID_STAT: word = scatter(stat_q);
      RID_MASK: word = scatter(mask_q);
      default:  word = '0;
    endcase
    rdata_d = re ? DATA_W'(word) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
  import ipi_hub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [10:0]       ch_req_in,
  input  logic [10:0]       obs_in,
  output logic [10:0]       trig_out,
  output logic [10:0]       obs_out,
  output logic              irq
);

  logic           we_trig;
  logic           we_stat;
  logic           we_en;
  logic           we_dis;
  logic           re;
  reg_id_e        rd_id;
  logic [NCH-1:0] wr_chan;
  logic [NCH-1:0] trig_q;
  logic [NCH-1:0] stat_q;
  logic [NCH-1:0] mask_q;

  ipi_hub_decode #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .we_trig   (we_trig),
    .we_stat   (we_stat),
    .we_en     (we_en),
    .we_dis    (we_dis),
    .re        (re),
    .rd_id     (rd_id),
    .wr_chan   (wr_chan)
  );

  ipi_hub_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_trig   (we_trig),
    .we_stat   (we_stat),
    .we_en     (we_en),
    .we_dis    (we_dis),
    .wr_chan   (wr_chan),
    .ch_req_in (ch_req_in),
    .trig_q    (trig_q),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .irq       (irq)
  );

  ipi_hub_rdmux #(
    .DATA_W (DATA_W)
  ) u_rdmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .re      (re),
    .rd_id   (rd_id),
    .stat_q  (stat_q),
    .mask_q  (mask_q),
    .obs_in  (obs_in),
    .rdata_q (rsp_rdata)
  );

  always_comb begin
    trig_out = trig_q;
    obs_out  = stat_q;
  end

endmodule

// File: rtl/ipi_hub_checker.sv
module ipi_hub_checker
  import ipi_hub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BE_W-1:0]   req_be,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [10:0]       ch_req_in,
  input logic [10:0]       trig_out,
  input logic [10:0]       obs_out,
  input logic              irq
);

  logic past_ok;
  logic trig_wr;
  logic rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  always_comb begin
    trig_wr = req_valid & req_write & (&req_be) & (req_addr == ADDR_W'(OFF_TRIG));
    rd_req  = req_valid & ~req_write;
  end

  // R3: a pulse only follows a trigger write
  a_r3_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (|trig_out)) |-> $past(trig_wr));

  // R4: no status bit appears without a request
  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((obs_out & ~$past(obs_out) & ~$past(ch_req_in)) == '0));

  // R5: a request always leaves its bit set, even against a clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((~obs_out & $past(ch_req_in)) == '0));

  // R8: the interrupt needs a latched status bit
  a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|obs_out));

  // R10: read data is zero unless a read was made the cycle before
  a_r10_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(rd_req)) |-> (rsp_rdata == '0));

  // R2: reserved bit positions never read as one
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rsp_rdata) & ~valid_mask()) == '0);

endmodule

bind ipi_hub ipi_hub_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_be    (req_be),
  .rsp_rdata (rsp_rdata),
  .ch_req_in (ch_req_in),
  .trig_out  (trig_out),
  .obs_out   (obs_out),
  .irq       (irq)
);

// File: tb/ipi_hub_bench.sv
`timescale 1ns/1ps
module ipi_hub_bench;

  localparam int CHB [11] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
  localparam logic [31:0] VMASK = 32'h0F0F0301;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [7:0]  req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic [10:0] ch_req_in;
  logic [10:0] obs_in;
  logic [10:0] trig_out;
  logic [10:0] obs_out;
  logic        irq;

  int n_chk;
  int n_fail;

  ipi_hub u_ipi_hub (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .ch_req_in (ch_req_in),
    .obs_in    (obs_in),
    .trig_out  (trig_out),
    .obs_out   (obs_out),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] to_word(input logic [10:0] v);
    logic [31:0] w = '0;
    for (int i = 0; i < 11; i++) w[CHB[i]] = v[i];
    return w;
  endfunction

  function automatic logic [10:0] to_chan(input logic [31:0] w);
    logic [10:0] v;
    for (int i = 0; i < 11; i++) v[i] = w[CHB[i]];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, register-word form
  logic [31:0] m_st, m_mask, m_rd;
  logic [10:0] m_trig;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st   = 0;
      m_mask = VMASK;
      m_rd   = 0;
      m_trig = 0;
    end else begin
      logic [31:0] nst, nmask, nrd;
      logic [10:0] ntrig;
      logic        full;
      full  = req_valid && (req_be == 4'hF);
      nst   = m_st;
      nmask = m_mask;
      nrd   = 0;
      ntrig = 0;
      if (full && !req_write) begin
        case (req_addr)
          8'h04: nrd = to_word(obs_in);
          8'h10: nrd = m_st;
          8'h14: nrd = m_mask;
          default: nrd = 0;
        endcase
      end
      if (full && req_write) begin
        case (req_addr)
          8'h00: ntrig = to_chan(req_wdata);
          8'h10: nst = nst & ~(req_wdata & VMASK);
          8'h18: nmask = nmask & ~(req_wdata & VMASK);
          8'h1C: nmask = nmask | (req_wdata & VMASK);
          default: ;
        endcase
      end
      nst    = nst | to_word(ch_req_in);
      m_st   = nst;
      m_mask = nmask;
      m_rd   = nrd;
      m_trig = ntrig;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 trig_out model", 32'(trig_out), 32'(m_trig));
      chk("R6 obs_out model", 32'(obs_out), 32'(to_chan(m_st)));
      chk("R8 irq model", 32'(irq), 32'(|(m_st & ~m_mask & VMASK)));
      chk("R10 rdata model", rsp_rdata, m_rd);
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    req_valid = 1; req_write = 0; req_addr = a; req_be = be;
    @(negedge clk);
    d = rsp_rdata;
    req_valid = 0;
  endtask

  initial begin
    logic [31:0] d;
    n_chk = 0; n_fail = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_be = 4'hF;
    req_wdata = 0; ch_req_in = 0; obs_in = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 trig_out", 32'(trig_out), 0);
    chk("R1 obs_out", 32'(obs_out), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(8'h14, d); chk("R1 mask reset", d, 32'h0F0F0301);
    rd(8'h10, d); chk("R1 status reset", d, 0);

    // R7 enable / disable / mask write
    wr(8'h18, 32'h0000_0300);
    rd(8'h14, d); chk("R7 enable clears", d, 32'h0F0F0001);
    rd(8'h18, d); chk("R7 enable reads zero", d, 0);
    rd(8'h1C, d); chk("R7 disable reads zero", d, 0);
    wr(8'h14, 32'h0);
    rd(8'h14, d); chk("R7 mask write ignored", d, 32'h0F0F0001);

    // R4 / R6 / R8 on a masked channel (bit 16 = channel 3)
    ch_req_in = 11'h008; @(negedge clk); ch_req_in = 0;
    chk("R6 obs follows status", 32'(obs_out), 32'h008);
    chk("R8 masked no irq", 32'(irq), 0);
    rd(8'h10, d); chk("R4 status set", d, 32'h0001_0000);
    wr(8'h18, 32'h0001_0000);
    chk("R8 unmask raises irq", 32'(irq), 1);
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R4 write zero keeps", d, 32'h0001_0000);
    wr(8'h10, 32'h0001_0000);
    chk("R4 w1c clears", 32'(obs_out), 0);
    chk("R8 irq drops", 32'(irq), 0);

    // R5 set wins over clear in the same cycle
    ch_req_in = 11'h008;
    wr(8'h10, 32'h0001_0000);
    ch_req_in = 0;
    rd(8'h10, d); chk("R5 set wins", d, 32'h0001_0000);
    wr(8'h10, 32'h0001_0000);

    // R2 reserved bits
    wr(8'h1C, 32'hF0F0FCFE);
    rd(8'h14, d); chk("R2 reserved disable ignored", d, 32'h0F0E0001);
    wr(8'h00, 32'hF0F0FCFE);
    chk("R2 reserved trigger ignored", 32'(trig_out), 0);
    wr(8'h00, 32'h0100_0000);
    chk("R2 bit24 is channel 7", 32'(trig_out), 32'h080);

    // R3 trigger pulse
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R3 pulse high", 32'(trig_out), 32'h7FF);
    @(negedge clk);
    chk("R3 pulse one cycle", 32'(trig_out), 0);
    rd(8'h00, d); chk("R3 trigger reads zero", d, 0);

    // R9 observation register
    obs_in = 11'h503;
    rd(8'h04, d); chk("R9 obs read", d, 32'h0A00_0101);
    wr(8'h04, 32'h0);
    rd(8'h04, d); chk("R9 obs write ignored", d, 32'h0A00_0101);
    obs_in = 0;

    // R10 unmapped reads and idle data
    rd(8'h08, d); chk("R10 unmapped 0x08", d, 0);
    rd(8'hFC, d); chk("R10 unmapped 0xFC", d, 0);
    @(negedge clk);
    chk("R10 idle zero", rsp_rdata, 0);

    // R11 partial accesses
    wr(8'h1C, 32'h0F0F0301, 4'h7);
    rd(8'h14, d); chk("R11 partial write ignored", d, 32'h0F0E0001);
    rd(8'h14, d, 4'h3); chk("R11 partial read zero", d, 0);

    // R8 unmasked channel 1 (bit 8), then masked again by disable
    ch_req_in = 11'h002; @(negedge clk); ch_req_in = 0;
    chk("R8 unmasked irq", 32'(irq), 1);
    wr(8'h1C, 32'h0000_0100);
    chk("R8 disable masks irq", 32'(irq), 0);
    chk("R6 status kept while masked", 32'(obs_out), 32'h002);
    wr(8'h10, 32'h0000_0100);

    // Random phase, checked every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      ch_req_in = 11'($urandom & $urandom & $urandom);
      obs_in    = 11'($urandom);
      req_valid = (op != 0);
      req_write = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 6))
        0: req_addr = 8'h00;
        1: req_addr = 8'h04;
        2: req_addr = 8'h10;
        3: req_addr = 8'h14;
        4: req_addr = 8'h18;
        5: req_addr = 8'h1C;
        default: req_addr = 8'h08;
      endcase
      req_be    = ($urandom_range(0, 7) == 0) ? 4'h5 : 4'hF;
      req_wdata = $urandom;
      @(negedge clk);
    end
    req_valid = 0; ch_req_in = 0; obs_in = 0;
    repeat (3) @(negedge clk);

    report();
    $finish;
  end

endmodule